// File: doc/BRIEF.md
# Predicated Halfword Prefetch Sequencer

This block takes one decoded vector prefetch command at a time and turns it into a stream of per-element prefetch hint requests. A command brings a 64-bit general-register base value, a stack-pointer value, the two register numbers, a 64-bit starting index, a predicate mask with one bit per byte of the vector, and a 4-bit operation field. The vector length is fixed by a parameter. It is a multiple of 128 bits between 128 and 2048, and it gives VLEN/16 halfword elements per command.

The elements are walked in ascending order, at most one per clock. Element e sits at the base plus twice (index + e), computed modulo 2^64. An element whose governing predicate bit is set produces one request on a valid/ready channel. The request carries the address and the decoded hint: read or write, target cache level, and streaming. An element that is predicated off produces no request, but it still uses its cycle and still advances the running index. The index given with the command is never returned. A command that names register 31 as its index register is rejected with an error pulse and produces no requests.

Top module: `pfh_seq`

## Requirements
- R1: The request for element e carries address base + ((index + e) << 1), with 64-bit wraparound. The index counts every element, whether or not it is active.
- R2: Element e is active when predicate bit 2*e is 1. Odd predicate bits are ignored. Exactly one request is issued for each active element and none for inactive ones, in ascending element order.
- R3: Every request carries req_write = op[3] (0 read, 1 write), req_level = op[2:1] as an unsigned level 0 to 3, and req_stream = op[0].
- R4: When cmd_rn is 31 the base is taken from cmd_sp. Otherwise it is taken from cmd_gpr_base.
- R5: A command with cmd_rm equal to 31 raises err for exactly the one cycle after it is accepted. It issues no request, raises no done, and leaves the block idle.
- R6: cmd_ready is 1 exactly when the block is idle, and a command is taken on a clock edge where cmd_valid and cmd_ready are both 1. After a valid command is taken, cmd_ready is 0 until the command completes.
- R7: While req_valid is 1 and req_ready is 0, the request stays valid and its address and hint fields do not change.
- R8: done pulses for one cycle in the cycle after the last element advances. When req_ready is held at 1, done appears VLEN/16 + 1 cycles after the accepting edge. This includes a command with no active elements.
- R9: Out of reset, cmd_ready is 1 and req_valid, done and err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command can be taken |
| cmd_rn | input | 5 | Base register number (31 selects cmd_sp) |
| cmd_rm | input | 5 | Index register number (31 is rejected) |
| cmd_gpr_base | input | 64 | Base value read from the general register |
| cmd_sp | input | 64 | Stack-pointer value |
| cmd_index | input | 64 | Starting element index |
| cmd_pred | input | VLEN/8 | Predicate, one bit per byte |
| cmd_op | input | 4 | Operation: [3] write, [2:1] level, [0] streaming |
| req_valid | output | 1 | Prefetch request valid |
| req_ready | input | 1 | Prefetch request taken |
| req_addr | output | 64 | Element address |
| req_write | output | 1 | Hint: 1 write, 0 read |
| req_level | output | 2 | Target cache level |
| req_stream | output | 1 | Streaming (non-temporal) hint |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
A wrong running address is visible at once on the first active element after the fault. Because the address advances on every element, a missed or doubled step shifts every later request by two bytes. A predicate pointer that falls out of step shows up as requests for the wrong elements or a wrong request count by the time done arrives. An element counter that is off by one moves done away from its expected cycle when req_ready is held high. An error in the stall hold shows up in the cycle after the first back-pressured request, when the request fields change.

// File: rtl/pfh_seq.sv
module pfh_seq #(
  parameter int VLEN = 512
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic [4:0]          cmd_rn,
  input  logic [4:0]          cmd_rm,
  input  logic [63:0]         cmd_gpr_base,
  input  logic [63:0]         cmd_sp,
  input  logic [63:0]         cmd_index,
  input  logic [VLEN/8-1:0]   cmd_pred,
  input  logic [3:0]          cmd_op,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [63:0]         req_addr,
  output logic                req_write,
  output logic [1:0]          req_level,
  output logic                req_stream,
  output logic                done,
  output logic                err
);
  localparam int NELEM = VLEN / 16;
  localparam int PW    = VLEN / 8;
  localparam int EW    = (NELEM > 1) ? $clog2(NELEM) : 1;
  localparam logic [EW-1:0] LAST = EW'(NELEM - 1);

  logic          busy;
  logic [63:0]   addr_q;
  logic [PW-1:0] pred_q;
  logic [3:0]    op_q;
  logic [EW-1:0] elem_q;
  logic          done_q, err_q;

  wire [63:0] base_sel = (cmd_rn == 5'd31) ? cmd_sp : cmd_gpr_base;
  wire        take     = cmd_valid && !busy;
  wire        bad      = cmd_rm == 5'd31;
  wire        step     = busy && (!req_valid || req_ready);

  assign cmd_ready  = !busy;
  assign req_valid  = busy && pred_q[0];
  assign req_addr   = addr_q;
  assign req_write  = op_q[3];
  assign req_level  = op_q[2:1];
  assign req_stream = op_q[0];
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      addr_q <= '0;
      pred_q <= '0;
      op_q   <= '0;
      elem_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (take) begin
        if (bad) begin
          err_q <= 1'b1;
        end else begin
          busy   <= 1'b1;
          addr_q <= base_sel + {cmd_index[62:0], 1'b0};
          pred_q <= cmd_pred;
          op_q   <= cmd_op;
          elem_q <= '0;
        end
      end else if (step) begin
        addr_q <= addr_q + 64'd2;
        pred_q <= pred_q >> 2;
        elem_q <= elem_q + 1'b1;
        if (elem_q == LAST) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end
endmodule

module pfh_seq_chk #(
  parameter int VLEN = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [4:0]        cmd_rm,
  input logic              req_valid,
  input logic              req_ready,
  input logic [63:0]       req_addr,
  input logic              req_write,
  input logic [1:0]        req_level,
  input logic              req_stream,
  input logic              done,
  input logic              err
);
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !cmd_ready); // R6
  AST_ACCEPT_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_rm != 5'd31 |=> !cmd_ready && !err); // R6
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write)
      && $stable(req_level) && $stable(req_stream)); // R7
  AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_rm == 5'd31 |=> err && cmd_ready && !req_valid && !done); // R5
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err || cmd_ready); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready && !req_valid && !err); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

bind pfh_seq pfh_seq_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_rm(cmd_rm), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_write(req_write), .req_level(req_level),
  .req_stream(req_stream), .done(done), .err(err)
);

// File: tb/test_pfh_seq.sv
module test_pfh_seq;
  localparam int VLEN  = 512;
  localparam int NELEM = VLEN / 16;
  localparam int PW    = VLEN / 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, req_ready = 1'b0;
  logic cmd_ready, req_valid, req_write, req_stream, done, err;
  logic [4:0] cmd_rn = '0, cmd_rm = '0;
  logic [63:0] cmd_gpr_base = '0, cmd_sp = '0, cmd_index = '0, req_addr;
  logic [PW-1:0] cmd_pred = '0;
  logic [3:0] cmd_op = '0;
  logic [1:0] req_level;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  pfh_seq #(.VLEN(VLEN)) i_pfh_seq (.*);

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int next_active(input logic [PW-1:0] p, input int from);
    for (int e = from; e < NELEM; e++) if (p[2*e]) return e;
    return NELEM;
  endfunction

  function automatic int count_active(input logic [PW-1:0] p);
    int c = 0;
    for (int e = 0; e < NELEM; e++) if (p[2*e]) c++;
    return c;
  endfunction

  task automatic run_cmd(input logic [4:0] rn, input logic [4:0] rm, input logic [63:0] gb,
                         input logic [63:0] sp, input logic [63:0] ix, input logic [PW-1:0] pr,
                         input logic [3:0] op, input bit rnd);
    logic [63:0] eb, pa, ea;
    int cur, cyc, nreq, e, quiet;
    bit fin, pst, rdy;
    eb = (rn == 5'd31) ? sp : gb;
    cur = 0; cyc = 1; nreq = 0; fin = 0; pst = 0; pa = '0;
    @(negedge clk);
    cmd_rn = rn; cmd_rm = rm; cmd_gpr_base = gb; cmd_sp = sp;
    cmd_index = ix; cmd_pred = pr; cmd_op = op; cmd_valid = 1'b1;
    check(cmd_ready == 1'b1, "R6 ready when idle", 64'(cmd_ready), 64'd1);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rm == 5'd31) begin
      check(err == 1'b1, "R5 err pulse", 64'(err), 64'd1);
      quiet = 1;
      for (int k = 0; k < NELEM + 3; k++) begin
        @(negedge clk);
        if (req_valid || done || err || !cmd_ready) quiet = 0;
      end
      check(quiet == 1, "R5 rejected command stays quiet", 64'(quiet), 64'd1);
      return;
    end
    check(cmd_ready == 1'b0, "R6 busy after accept", 64'(cmd_ready), 64'd0);
    while (!fin && cyc < 4 * NELEM + 50) begin
      if (pst) check(req_valid && req_addr == pa, "R7 stall hold", req_addr, pa);
      if (req_valid) begin
        e = next_active(pr, cur);
        if (e >= NELEM) check(1'b0, "R2 unexpected request", req_addr, 64'd0);
        else begin
          ea = eb + ((ix + 64'(e)) << 1);
          check(req_addr == ea, (rn == 5'd31) ? "R4 sp base address" : "R1 address", req_addr, ea);
          check({req_write, req_level, req_stream} == op, "R3 hint fields",
                64'({req_write, req_level, req_stream}), 64'(op));
        end
      end
      rdy = rnd ? (($urandom % 3) != 0) : 1'b1;
      req_ready = rdy;
      pst = req_valid && !rdy;
      pa = req_addr;
      if (req_valid && rdy) begin
        cur = next_active(pr, cur) + 1;
        nreq++;
      end
      if (done) begin
        fin = 1;
        check(nreq == count_active(pr), "R2 request count", 64'(nreq), 64'(count_active(pr)));
        if (!rnd) check(cyc == NELEM + 1, "R8 done timing", 64'(cyc), 64'(NELEM + 1));
      end
      @(negedge clk);
      cyc++;
    end
    if (!fin) check(1'b0, "R8 done never seen", 64'(cyc), 64'(NELEM + 1));
    check(done == 1'b0, "R8 done single pulse", 64'(done), 64'd0);
    req_ready = 1'b0;
  endtask

  function automatic logic [PW-1:0] rand_pred(input int density);
    logic [PW-1:0] p;
    for (int i = 0; i < PW; i++) p[i] = (($urandom % 100) < density);
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [PW-1:0] odd;
    void'($urandom(32'd4711));
    for (int i = 0; i < PW; i++) odd[i] = i[0];
    repeat (3) @(negedge clk);
    check(cmd_ready && !req_valid && !done && !err, "R9 reset state",
          64'({cmd_ready, req_valid, done, err}), 64'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready && !req_valid && !done && !err, "R9 idle after reset",
          64'({cmd_ready, req_valid, done, err}), 64'b1000);
    run_cmd(5'd3, 5'd4, 64'h1000, 64'h9000, 64'd5, '0, 4'h0, 1'b0);
    run_cmd(5'd3, 5'd4, 64'h2000, 64'h9000, 64'd0, '1, 4'hB, 1'b0);
    run_cmd(5'd3, 5'd4, 64'h2000, 64'h9000, 64'd0, odd, 4'h5, 1'b0);
    run_cmd(5'd31, 5'd4, 64'h2000, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, '1, 4'h6, 1'b0);
    run_cmd(5'd2, 5'd7, 64'h40, 64'h0, 64'hFFFF_FFFF_FFFF_FFFE, '1, 4'h9, 1'b1);
    run_cmd(5'd2, 5'd31, 64'h40, 64'h0, 64'd0, '1, 4'h1, 1'b0);
    for (int t = 0; t < 40; t++) begin
      run_cmd(5'($urandom % 32), 5'($urandom % 31), {$urandom, $urandom}, {$urandom, $urandom},
              {$urandom, $urandom}, rand_pred(int'($urandom % 101)), 4'($urandom), 1'($urandom));
    end
    run_cmd(5'd31, 5'd31, 64'h0, 64'h0, 64'd0, '1, 4'hF, 1'b1);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule